// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a raw "supply is low" comparator flag and the sensed level of a shared, bidirectional reset pad into a clean system reset. Both inputs pass through counter-based glitch filters. Any accepted cause asserts reset. Reset is then held for a fixed number of clock cycles after the last cause goes away, so downstream logic always sees a full-length reset pulse.

The shared pad carries the block's own active-low reset drive and also acts as a push-button input. A falling edge that an external agent puts on the pad starts a full timeout, however short the press. While the block itself pulls the pad low, the low level that echoes back into the sense input does not count as a press. Three outputs come from one internal reset state: an active-low reset, an active-high reset, and a flag that blocks the memory from starting any operation.

All delays are parameters counted in clock cycles. At a 50 MHz clock, the defaults give a hold time of about 200 ms and filter widths of about 40 ns on the supply flag and 100 ns on the pad. Simulation uses much shorter values.

Top module: `supply_reset_seq`

## Requirements
- R1: While `arst_n` is low, `rst_o`=1, `rst_no`=0 and `mem_inhibit_o`=1. After `arst_n` rises with the supply flag low, reset is released on exactly the `SUPPLY_FILT_CYCLES+HOLD_CYCLES`-th rising clock edge.
- R2: Reset asserts on the `SUPPLY_FILT_CYCLES+1`-th edge after `supply_low_i` goes to 1 and stays at 1. It remains asserted for as long as the filtered supply flag is 1.
- R3: A pulse of 1 on `supply_low_i` lasting fewer than `SUPPLY_FILT_CYCLES` clock edges never asserts reset.
- R4: After `supply_low_i` returns to 0, reset is released on exactly the `SUPPLY_FILT_CYCLES+HOLD_CYCLES`-th edge.
- R5: A high-to-low change on `mr_pin_i` that stays low for `PAD_FILT_CYCLES` edges asserts reset on the `PAD_FILT_CYCLES+1`-th edge. The input is edge-triggered: reset is released `HOLD_CYCLES` edges later even if the pin is still held low.
- R6: A manual press shorter than the hold time still gives reset for the full `HOLD_CYCLES` edges.
- R7: A low pulse on `mr_pin_i` lasting fewer than `PAD_FILT_CYCLES` edges never asserts reset.
- R8: When reset is caused by the supply and the pad then falls because of the block's own drive, that fall is not taken as a press. The release time stays as stated in R4.
- R9: A new accepted falling edge on `mr_pin_i` while reset is active restarts the full hold count.
- R10: `rst_no` is always the inverse of `rst_o`, and `mem_inhibit_o` always equals `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_low_i | input | 1 | Comparator flag, 1 = supply below threshold |
| mr_pin_i | input | 1 | Sensed level of the shared reset pad (1 = high) |
| rst_no | output | 1 | Reset, active low (drives the shared pad) |
| rst_o | output | 1 | Reset, active high |
| mem_inhibit_o | output | 1 | 1 = memory must not start any operation |

## Verification
The assertions assume that both inputs are already synchronous to `clk`. They also assume that the pad sense drops only after `rst_no` has fallen, never in the same cycle. The bench drives every input on the falling clock edge. It models the pad as the external press ANDed with `rst_no`, so the block's own drive echoes back with a full cycle of delay. The bench switches off the pad model only to inject a fresh press during an active reset.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

    // State kept by the pad edge tracker.
    typedef struct packed {
        logic prev;      // filtered pad level in the previous cycle
        logic echo;      // a fall caused by our own drive is still expected
        logic rst_prev;  // reset state in the previous cycle
    } pad_track_t;

    // Counter width able to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srt_glitch_filter.sv
module srt_glitch_filter #(
    parameter int unsigned STABLE_CYCLES = 4,
    parameter logic        INIT_LEVEL    = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic raw_i,
    output logic level_o
);
    import supply_reset_pkg::*;

    localparam int unsigned CW = cnt_width(STABLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.level = raw_i;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.level <= INIT_LEVEL;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/srt_pad_edge.sv
module srt_pad_edge (
    input  logic clk,
    input  logic arst_n,
    input  logic level_i,
    input  logic rst_active_i,
    output logic fall_o
);
    import supply_reset_pkg::*;

    pad_track_t st_q, st_d;
    logic       rst_rise;

    assign rst_rise = rst_active_i & ~st_q.rst_prev;

    always_comb begin
        st_d          = st_q;
        st_d.prev     = level_i;
        st_d.rst_prev = rst_active_i;
        if (!rst_active_i) begin
            st_d.echo = 1'b0;
        end else if (rst_rise && level_i) begin
            st_d.echo = 1'b1;
        end else if (!level_i) begin
            st_d.echo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.prev     <= 1'b1;
            st_q.echo     <= 1'b1;
            st_q.rst_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.prev & ~level_i & ~st_q.echo;
endmodule

// File: rtl/srt_hold_timer.sv
module srt_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 40
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hold_i,
    input  logic restart_i,
    output logic active_o
);
    import supply_reset_pkg::*;

    localparam int unsigned CW = cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (hold_i || restart_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int unsigned HOLD_CYCLES        = 10_000_000,
    parameter int unsigned SUPPLY_FILT_CYCLES = 2,
    parameter int unsigned PAD_FILT_CYCLES    = 5
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low_i,
    input  logic mr_pin_i,
    output logic rst_no,
    output logic rst_o,
    output logic mem_inhibit_o
);
    logic supply_level;
    logic pad_level;
    logic pad_fall;
    logic rst_active;

    srt_glitch_filter #(
        .STABLE_CYCLES(SUPPLY_FILT_CYCLES),
        .INIT_LEVEL   (1'b1)
    ) supply_filt_i (
        .clk    (clk),
        .arst_n (arst_n),
        .raw_i  (supply_low_i),
        .level_o(supply_level)
    );

    srt_glitch_filter #(
        .STABLE_CYCLES(PAD_FILT_CYCLES),
        .INIT_LEVEL   (1'b1)
    ) pad_filt_i (
        .clk    (clk),
        .arst_n (arst_n),
        .raw_i  (mr_pin_i),
        .level_o(pad_level)
    );

    srt_pad_edge pad_edge_i (
        .clk         (clk),
        .arst_n      (arst_n),
        .level_i     (pad_level),
        .rst_active_i(rst_active),
        .fall_o      (pad_fall)
    );

    srt_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) timer_i (
        .clk      (clk),
        .arst_n   (arst_n),
        .hold_i   (supply_level),
        .restart_i(pad_fall),
        .active_o (rst_active)
    );

    assign rst_o         = rst_active;
    assign rst_no        = ~rst_active;
    assign mem_inhibit_o = rst_active;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
    parameter int unsigned HOLD_CYCLES = 40
) (
    input logic clk,
    input logic arst_n,
    input logic supply_flt_i,
    input logic pad_fall_i,
    input logic rst_i,
    input logic rst_n_i,
    input logic inhibit_i
);
    // Counts edges since the last accepted cause, saturating at the hold time.
    logic [31:0] quiet_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            quiet_q <= '0;
        end else if (supply_flt_i || pad_fall_i) begin
            quiet_q <= '0;
        end else if (quiet_q != 32'(HOLD_CYCLES)) begin
            quiet_q <= quiet_q + 32'd1;
        end
    end

    AST_POLARITY_MATCH: assert property (@(posedge clk) disable iff (!arst_n) rst_n_i == !rst_i); // R10
    AST_INHIBIT_MATCH: assert property (@(posedge clk) disable iff (!arst_n) inhibit_i == rst_i); // R10
    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!arst_n) supply_flt_i |=> rst_i); // R2
    AST_PRESS_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n) pad_fall_i |=> rst_i); // R5
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!arst_n) $rose(rst_i) |-> $past(supply_flt_i || pad_fall_i)); // R2
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!arst_n) $fell(rst_i) |-> quiet_q == 32'(HOLD_CYCLES)); // R4
endmodule

bind supply_reset_seq supply_reset_seq_chk #(
    .HOLD_CYCLES(HOLD_CYCLES)
) chk_i (
    .clk         (clk),
    .arst_n      (arst_n),
    .supply_flt_i(supply_level),
    .pad_fall_i  (pad_fall),
    .rst_i       (rst_o),
    .rst_n_i     (rst_no),
    .inhibit_i   (mem_inhibit_o)
);

// File: tb/supply_reset_seq_tb_top.sv
`timescale 1ns/1ps
module supply_reset_seq_tb_top;
    localparam int unsigned T = 40;
    localparam int unsigned G = 4;
    localparam int unsigned M = 6;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_low = 1'b0;
    logic mr_ext = 1'b1;
    logic pad_en = 1'b1;
    logic mr_pin;
    logic rst_no, rst_o, mem_inhibit;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    // Pad model: open-drain wired-AND of external press and own drive.
    assign mr_pin = mr_ext & (rst_no | ~pad_en);

    supply_reset_seq #(
        .HOLD_CYCLES       (T),
        .SUPPLY_FILT_CYCLES(G),
        .PAD_FILT_CYCLES   (M)
    ) dut_i (
        .clk          (clk),
        .arst_n       (arst_n),
        .supply_low_i (supply_low),
        .mr_pin_i     (mr_pin),
        .rst_no       (rst_no),
        .rst_o        (rst_o),
        .mem_inhibit_o(mem_inhibit)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rst(input string req, input logic exp);
        tests++;
        if (rst_o !== exp || rst_no !== ~exp || mem_inhibit !== exp) begin
            fails++;
            $display("FAIL %s: rst_o=%b rst_no=%b inhibit=%b, expected rst_o=%b rst_no=%b inhibit=%b",
                     req, rst_o, rst_no, mem_inhibit, exp, ~exp, exp);
        end
    endtask

    task automatic t_power_on();
        arst_n = 1'b0;
        step(3);
        chk_rst("R1", 1'b1);
        arst_n = 1'b1;
        step(G + T - 1);
        chk_rst("R1", 1'b1);
        step(1);
        chk_rst("R1", 1'b0);
        step(M + 4);
        chk_rst("R10", 1'b0);
    endtask

    task automatic t_supply_dip(input int len, input string rel_req);
        supply_low = 1'b1;
        step(G);
        chk_rst("R2", 1'b0);
        step(1);
        chk_rst("R2", 1'b1);
        step(len - G - 1);
        chk_rst("R2", 1'b1);
        supply_low = 1'b0;
        step(G + T - 1);
        chk_rst(rel_req, 1'b1);
        step(1);
        chk_rst(rel_req, 1'b0);
        step(M + 4);
        chk_rst("R8", 1'b0);
    endtask

    task automatic t_supply_glitch();
        supply_low = 1'b1;
        step(G - 1);
        supply_low = 1'b0;
        for (int i = 0; i < 3 * int'(G); i++) begin
            step(1);
            chk_rst("R3", 1'b0);
        end
    endtask

    task automatic t_press_short(input int len);
        mr_ext = 1'b0;
        step(M);
        chk_rst("R5", 1'b0);
        step(1);
        chk_rst("R5", 1'b1);
        step(len - M - 1);
        mr_ext = 1'b1;
        step(M + T - len);
        chk_rst("R6", 1'b1);
        step(1);
        chk_rst("R6", 1'b0);
        step(M + 3);
        chk_rst("R6", 1'b0);
    endtask

    task automatic t_press_held();
        mr_ext = 1'b0;
        step(M + T);
        chk_rst("R5", 1'b1);
        step(1);
        chk_rst("R5", 1'b0);
        step(5);
        chk_rst("R5", 1'b0);
        mr_ext = 1'b1;
        step(M + 3);
        chk_rst("R5", 1'b0);
    endtask

    task automatic t_press_glitch();
        mr_ext = 1'b0;
        step(M - 1);
        mr_ext = 1'b1;
        for (int i = 0; i < 2 * int'(M); i++) begin
            step(1);
            chk_rst("R7", 1'b0);
        end
    endtask

    task automatic t_restart();
        pad_en = 1'b0;
        mr_ext = 1'b0;
        step(M + 1);
        chk_rst("R9", 1'b1);
        step(1);
        mr_ext = 1'b1;
        step(M + 2);
        mr_ext = 1'b0;
        step(M + T);
        chk_rst("R9", 1'b1);
        step(1);
        chk_rst("R9", 1'b0);
        mr_ext = 1'b1;
        step(M + 3);
        pad_en = 1'b1;
        chk_rst("R9", 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(1);
        t_power_on();
        t_supply_dip(G + 1, "R8");
        t_supply_dip(60, "R4");
        t_supply_glitch();
        t_press_short(M + 2);
        t_press_held();
        t_press_glitch();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule